// File: doc/BRIEF.md
# Configurable Bandwidth Event Counter

This block keeps byte counters for memory traffic in one monitoring domain. Each counter belongs to one resource monitoring ID (RMID) and one of two events, "total" and "local". Every clock, the block can take one transaction report. The report carries an RMID, a one-hot category code and a byte count. The block adds the byte count to the counter of each event whose 7-bit category mask has that category bit set.

Both masks are shared across the domain and can be rewritten through a small write port. A rewrite of either mask invalidates every counter of both events. After a rewrite, the first read of each counter reports that the counter is unavailable, and later reads return the bytes counted since the rewrite.

A read port takes an RMID and an event code and returns the count one cycle later.

Top module: `bw_event_counter`

## Requirements
- R1: After reset, the total mask reads 0x7F, the local mask reads 0x15, and every counter reads as available with a value of zero.
- R2: A valid transaction carries a one-hot category code in `txn_cat`. It adds `txn_bytes` to the total counter of its RMID when the total mask has that category bit set. The category bits are:
  - bit 0: local reads
  - bit 1: remote reads
  - bit 2: local non-temporal writes
  - bit 3: remote non-temporal writes
  - bit 4: local slow-memory reads
  - bit 5: remote slow-memory reads
  - bit 6: dirty victims
- R3: The local counter uses the local mask in the same way. With the default mask 0x15, only categories 0, 2 and 4 reach it.
- R4: A write with `cfg_sel`=0 updates the total mask, and a write with `cfg_sel`=1 updates the local mask. Only `cfg_wdata[6:0]` is stored, and the upper bits have no effect. The new mask shows on the mask outputs one cycle after the write.
- R5: Any mask write resets the counters of both events for all RMIDs to zero.
- R6: After a mask write, the first read of each counter returns `rd_unavail`=1 with `rd_count`=0. Later reads of that counter return `rd_unavail`=0 and the accumulated value.
- R7: A transaction in the same cycle as a mask write is dropped. A read in that cycle returns the values from before the clear, and its counter remains marked unavailable.
- R8: A counter saturates at its all-ones value and does not wrap.
- R9: `rd_valid` pulses exactly one cycle after `rd_req`. The returned value counts transactions from earlier cycles but not from the request cycle. `rd_evt`=0 selects total and `rd_evt`=1 selects local.
- R10: A transaction affects only the counters of its own RMID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_valid | input | 1 | Transaction report valid |
| txn_id | input | ID_W | RMID of the transaction |
| txn_cat | input | 7 | One-hot category code |
| txn_bytes | input | BYTE_W | Byte count of the transaction |
| cfg_we | input | 1 | Mask write strobe |
| cfg_sel | input | 1 | Mask select: 0 total, 1 local |
| cfg_wdata | input | WDATA_W | Mask write data; only bits 6:0 are used |
| rd_req | input | 1 | Read request |
| rd_id | input | ID_W | RMID to read |
| rd_evt | input | 1 | Event to read: 0 total, 1 local |
| rd_valid | output | 1 | Read response valid |
| rd_count | output | CNT_W | Counter value |
| rd_unavail | output | 1 | Counter unavailable since the last clear |
| mask_total | output | 7 | Current total-event mask |
| mask_local | output | 7 | Current local-event mask |

## Verification
Transactions and mask writes change the internal state at the clock edge that samples them. A read response is due at the edge after `rd_req`, and a new mask shows on its output port at the edge after the write. The bench drives inputs on falling edges. At each rising edge, its behavioural model applies the same sampled inputs: it computes the response from the state before the edge, and then applies the updates, with the clear taking priority. On the next falling edge, the bench compares the response and mask ports against the model. This puts each expected value in exactly the cycle where the registered outputs should hold it, including the cycles where a read, a transaction and a mask write collide.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int CAT_N = 7;
  localparam logic [CAT_N-1:0] TOTAL_MASK_RST = 7'h7F;
  localparam logic [CAT_N-1:0] LOCAL_MASK_RST = 7'h15;
  localparam int NUM_EVT = 2;

  typedef enum logic {
    EVT_TOTAL = 1'b0,
    EVT_LOCAL = 1'b1
  } evt_e;
endpackage

// File: rtl/bwc_mask_regs.sv
module bwc_mask_regs
  import bwc_pkg::*;
#(
  parameter int WDATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [WDATA_W-1:0] cfg_wdata,
  output logic [CAT_N-1:0]   mask_total_q,
  output logic [CAT_N-1:0]   mask_local_q,
  output logic               clr_o
);
  // Only the category bits are kept; the rest of the write word is dropped.
  logic [CAT_N-1:0] wr_bits;
  assign wr_bits = cfg_wdata[CAT_N-1:0];
  assign clr_o   = cfg_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_total_q <= TOTAL_MASK_RST;
      mask_local_q <= LOCAL_MASK_RST;
    end else if (cfg_we) begin
      if (cfg_sel == EVT_LOCAL) mask_local_q <= wr_bits;
      else                      mask_total_q <= wr_bits;
    end
  end

  p_rst_masks_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_total_q == TOTAL_MASK_RST && mask_local_q == LOCAL_MASK_RST));

  p_mask_low_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == EVT_TOTAL) |=> (mask_total_q == $past(cfg_wdata[CAT_N-1:0])));

  p_mask_local_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == EVT_LOCAL) |=> (mask_local_q == $past(cfg_wdata[CAT_N-1:0])));
endmodule

// File: rtl/bwc_event_bank.sv
module bwc_event_bank
  import bwc_pkg::*;
#(
  parameter int NUM_ID = 16,
  parameter int CNT_W  = 48,
  parameter int BYTE_W = 16,
  localparam int ID_W  = $clog2(NUM_ID)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic [CAT_N-1:0]  mask_i,
  input  logic              txn_valid,
  input  logic [ID_W-1:0]   txn_id,
  input  logic [CAT_N-1:0]  txn_cat,
  input  logic [BYTE_W-1:0] txn_bytes,
  input  logic              rd_req_i,
  input  logic [ID_W-1:0]   rd_id_i,
  output logic [CNT_W-1:0]  rd_cnt_q,
  output logic              rd_unav_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Counter storage has no reset; the stale bits mark its content as zero.
  logic [CNT_W-1:0]  mem [NUM_ID];
  logic [NUM_ID-1:0] stale_q;
  logic [NUM_ID-1:0] fresh_q;

  logic             hit;
  logic [CNT_W-1:0] acc_base;
  logic [CNT_W:0]   acc_sum;
  logic [CNT_W-1:0] acc_next;
  logic [CNT_W-1:0] rd_base;

  assign hit      = txn_valid && (|(txn_cat & mask_i)) && !clr_i;
  assign acc_base = stale_q[txn_id] ? '0 : mem[txn_id];
  assign acc_sum  = {1'b0, acc_base} + {{(CNT_W + 1 - BYTE_W){1'b0}}, txn_bytes};
  assign acc_next = acc_sum[CNT_W] ? CNT_MAX : acc_sum[CNT_W-1:0];
  assign rd_base  = stale_q[rd_id_i] ? '0 : mem[rd_id_i];

  always_ff @(posedge clk) begin
    if (hit) mem[txn_id] <= acc_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stale_q <= '1;
      fresh_q <= '0;
    end else if (clr_i) begin
      stale_q <= '1;
      fresh_q <= '1;
    end else begin
      if (hit)      stale_q[txn_id]  <= 1'b0;
      if (rd_req_i) fresh_q[rd_id_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt_q  <= '0;
      rd_unav_q <= 1'b0;
    end else if (rd_req_i) begin
      rd_unav_q <= fresh_q[rd_id_i];
      rd_cnt_q  <= fresh_q[rd_id_i] ? '0 : rd_base;
    end
  end

  p_clear_all_r5: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> ((&stale_q) && (&fresh_q)));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (hit && !stale_q[txn_id]) |=> (mem[$past(txn_id)] >= $past(mem[txn_id])));

  p_unav_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rd_unav_q |-> (rd_cnt_q == '0));
endmodule

// File: rtl/bw_event_counter.sv
module bw_event_counter
  import bwc_pkg::*;
#(
  parameter int NUM_ID  = 16,
  parameter int CNT_W   = 48,
  parameter int BYTE_W  = 16,
  parameter int WDATA_W = 32,
  localparam int ID_W   = $clog2(NUM_ID)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               txn_valid,
  input  logic [ID_W-1:0]    txn_id,
  input  logic [6:0]         txn_cat,
  input  logic [BYTE_W-1:0]  txn_bytes,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [WDATA_W-1:0] cfg_wdata,
  input  logic               rd_req,
  input  logic [ID_W-1:0]    rd_id,
  input  logic               rd_evt,
  output logic               rd_valid,
  output logic [CNT_W-1:0]   rd_count,
  output logic               rd_unavail,
  output logic [6:0]         mask_total,
  output logic [6:0]         mask_local
);
  logic clr;
  logic [CAT_N-1:0] mask_vec [NUM_EVT];
  logic [CNT_W-1:0] bank_cnt [NUM_EVT];
  logic [NUM_EVT-1:0] bank_unav;
  logic evt_q;

  bwc_mask_regs #(.WDATA_W(WDATA_W)) u_masks (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .mask_total_q (mask_total),
    .mask_local_q (mask_local),
    .clr_o        (clr)
  );

  assign mask_vec[EVT_TOTAL] = mask_total;
  assign mask_vec[EVT_LOCAL] = mask_local;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    bwc_event_bank #(
      .NUM_ID (NUM_ID),
      .CNT_W  (CNT_W),
      .BYTE_W (BYTE_W)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .clr_i     (clr),
      .mask_i    (mask_vec[g]),
      .txn_valid (txn_valid),
      .txn_id    (txn_id),
      .txn_cat   (txn_cat),
      .txn_bytes (txn_bytes),
      .rd_req_i  (rd_req && (rd_evt == 1'(g))),
      .rd_id_i   (rd_id),
      .rd_cnt_q  (bank_cnt[g]),
      .rd_unav_q (bank_unav[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) evt_q <= rd_evt;
    end
  end

  assign rd_count   = bank_cnt[evt_q];
  assign rd_unavail = bank_unav[evt_q];

  p_rd_latency_r9: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

  p_rd_single_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);

  p_cat_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> $onehot0(txn_cat));
endmodule

// File: tb/bw_event_counter_bench.sv
module bw_event_counter_bench;
  localparam int NUM_ID = 16;
  localparam int CNT_W  = 20;
  localparam int BYTE_W = 16;
  localparam int ID_W   = 4;
  localparam longint unsigned MAXV = (64'd1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txn_valid = 0;
  logic [ID_W-1:0] txn_id = '0;
  logic [6:0] txn_cat = '0;
  logic [BYTE_W-1:0] txn_bytes = '0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = '0;
  logic rd_req = 0, rd_evt = 0;
  logic [ID_W-1:0] rd_id = '0;
  logic rd_valid, rd_unavail;
  logic [CNT_W-1:0] rd_count;
  logic [6:0] mask_total, mask_local;

  always #10 clk = ~clk;

  bw_event_counter #(.NUM_ID(NUM_ID), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_bw_event_counter (
    .clk(clk), .rst(rst), .txn_valid(txn_valid), .txn_id(txn_id), .txn_cat(txn_cat),
    .txn_bytes(txn_bytes), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_req(rd_req), .rd_id(rd_id), .rd_evt(rd_evt), .rd_valid(rd_valid),
    .rd_count(rd_count), .rd_unavail(rd_unavail), .mask_total(mask_total),
    .mask_local(mask_local));

  // Behavioural reference model
  longint unsigned cnt [2][NUM_ID];
  bit fr [2][NUM_ID];
  logic [6:0] mk [2];
  logic exp_valid, exp_unav;
  longint unsigned exp_cnt;
  string cur_req = "R1";
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mk[0] = 7'h7F; mk[1] = 7'h15;
      for (int e = 0; e < 2; e++)
        for (int i = 0; i < NUM_ID; i++) begin cnt[e][i] = 0; fr[e][i] = 0; end
      exp_valid = 0; exp_unav = 0; exp_cnt = 0;
    end else begin
      exp_valid = rd_req;
      if (rd_req) begin
        exp_unav = fr[rd_evt][rd_id];
        exp_cnt  = exp_unav ? 0 : cnt[rd_evt][rd_id];
      end
      if (cfg_we) begin
        mk[cfg_sel] = cfg_wdata[6:0];
        for (int e = 0; e < 2; e++)
          for (int i = 0; i < NUM_ID; i++) begin cnt[e][i] = 0; fr[e][i] = 1; end
      end else begin
        if (rd_req) fr[rd_evt][rd_id] = 0;
        if (txn_valid)
          for (int e = 0; e < 2; e++)
            if ((txn_cat & mk[e]) != 0) begin
              cnt[e][txn_id] = cnt[e][txn_id] + txn_bytes;
              if (cnt[e][txn_id] > MAXV) cnt[e][txn_id] = MAXV;
            end
      end
    end
  end

  task automatic chk(input string what, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("mask_total", mask_total, mk[0]);
      chk("mask_local", mask_local, mk[1]);
      chk("rd_valid", rd_valid, exp_valid);
      if (exp_valid) begin
        chk("rd_unavail", rd_unavail, exp_unav);
        chk("rd_count", rd_count, exp_cnt);
      end
    end
  end

  task automatic drive(input bit tv, input int tid, input int cat, input int nb,
                       input bit we, input bit sel, input logic [31:0] wd,
                       input bit rq, input int rid, input bit re);
    @(negedge clk);
    txn_valid = tv; txn_id = tid[ID_W-1:0]; txn_cat = cat[6:0]; txn_bytes = nb[BYTE_W-1:0];
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    rd_req = rq; rd_id = rid[ID_W-1:0]; rd_evt = re;
  endtask

  task automatic txn(input int tid, input int cat, input int nb);
    drive(1, tid, 1 << cat, nb, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input int rid, input bit re);
    drive(0, 0, 0, 0, 0, 0, 0, 1, rid, re);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    idle(); rd(0, 0); rd(7, 1); idle();

    cur_req = "R2";
    for (int c = 0; c < 7; c++) txn(1, c, 100 + c);
    rd(1, 0); idle();
    cur_req = "R3";
    rd(1, 1); idle();

    cur_req = "R10";
    txn(2, 0, 55); txn(3, 6, 77);
    rd(2, 0); rd(3, 0); rd(3, 1); rd(1, 0); idle();

    cur_req = "R9";
    drive(1, 4, 1, 500, 0, 0, 0, 1, 4, 0);
    rd(4, 0); idle();

    cur_req = "R4";
    drive(0, 0, 0, 0, 1, 0, 32'hFFFF_FF33, 0, 0, 0);
    idle();
    cur_req = "R5";
    rd(1, 0); rd(1, 0); rd(2, 1); rd(2, 1);
    cur_req = "R6";
    txn(1, 4, 40); txn(1, 2, 40);
    rd(1, 0); rd(1, 1); rd(1, 1); idle();

    cur_req = "R7";
    drive(1, 5, 1, 900, 1, 1, 32'h0000_0130, 1, 1, 0);
    rd(1, 0); rd(5, 1); rd(5, 1); idle();
    txn(5, 5, 12); txn(5, 0, 12); rd(5, 1); idle();

    cur_req = "R8";
    for (int k = 0; k < 20; k++) txn(6, 4, 65535);
    rd(6, 0); rd(6, 0); rd(6, 1); rd(6, 1); idle();
    txn(6, 0, 9); rd(6, 0); idle();

    cur_req = "R4";
    drive(0, 0, 0, 0, 1, 1, 32'hABCD_EF15, 0, 0, 0);
    idle(); idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule